// File: doc/BRIEF.md
# Balanced-Weight Codeword Checker

This block checks whether a word of 2M bits carries exactly M ones. Its verdict comes out on two rails instead of a single error bit. On a good word exactly one rail is high. On a bad word both rails agree: both low if the word has too few ones, both high if it has too many. Because the verdict is itself a two-rail code, a rail stuck at one fixed value cannot hide an error indefinitely. Normal traffic of good words drives each rail to both values, so a fault on the checker's own outputs shows up during ordinary operation.

The word is split into two halves of M bits each. Half A is the low M bits and half B is the high M bits. For each half the block builds a ladder of "at least k ones" signals, using only AND and OR gates. It then pairs rung i of half A with rung M−i of half B. Pairs with an even index are ORed onto one rail and pairs with an odd index onto the other. The datapath is purely combinational. An optional register on the input and an optional register on the output can be enabled by parameter for timing closure. M may range from 2 to 8.

Top module: `balanced_word_checker`

## Requirements
- R1: For a word with exactly M ones whose low half (bits M−1..0) holds an even number of ones, railE0 is 1 and railE1 is 0.
- R2: For a word with exactly M ones whose low half holds an odd number of ones, railE0 is 0 and railE1 is 1.
- R3: For a word with fewer than M ones, both rails are 0.
- R4: For a word with more than M ones, both rails are 1.
- R5: The rails reflect the word presented REG_IN+REG_OUT rising clock edges earlier. Each enabled register adds exactly one cycle, and with both disabled the path is combinational.
- R6: While rstN is low, every enabled register clears: the input stage holds an all-zero word and the output stage holds rails 00. The rails therefore read 00 until the first word presented after reset arrives.
- R7: The per-half threshold signals are monotonic: when "at least k ones" is true, "at least k−1 ones" is also true.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional pipeline registers |
| rstN | input | 1 | Active-low synchronous reset of the pipeline registers |
| wordIn | input | 2*M | Word under test; bits M−1..0 form half A, the rest form half B |
| railE0 | output | 1 | Rail fed by the even-indexed threshold pairs |
| railE1 | output | 1 | Rail fed by the odd-indexed threshold pairs |

## Verification
The bench covers every word of the 2M-bit space for M=4, in ascending and then descending order. It therefore reaches words one bit above and one bit below the valid weight, all-zero and all-ones words, and valid words of every low-half parity. The following faults would each show up:
- Swapping the parity split, or pairing rungs with the wrong offset, puts a good word on the wrong rail or makes both rails fire.
- A rung index that is off by one lets a word of weight M±1 through as a single-rail result.
- A missing or extra pipeline stage shifts every result by a cycle. The model, which delays its expectations by exactly two cycles, catches this.
- A register that fails to clear on reset leaves a non-00 pair on the rails during reset.

// File: rtl/bwc_pkg.sv
package bwc_pkg;

  // Two-rail verdict: 10/01 mean a valid codeword, 00/11 mean an error.
  typedef struct packed {
    logic e0;
    logic e1;
  } railPair_t;

  localparam railPair_t RAIL_CLEAR = '{e0: 1'b0, e1: 1'b0};

endpackage

// File: rtl/bwc_threshold.sv
// Monotonic "at least k ones" ladder for one half of the word.
// atLeast[k] is 1 when bitsIn holds k or more ones; only AND/OR used.
module bwc_threshold #(
  parameter int N = 3
) (
  input  logic [N-1:0] bitsIn,
  output logic [N:0]   atLeast
);

  // stage[j][k]: at least k ones among bitsIn[j-1:0]
  logic [N:0] stage [N+1];

  assign stage[0][0] = 1'b1;
  for (genvar k = 1; k <= N; k++) begin : g_seed
    assign stage[0][k] = 1'b0;
  end

  for (genvar j = 0; j < N; j++) begin : g_bit
    assign stage[j+1][0] = 1'b1;
    for (genvar k = 1; k <= N; k++) begin : g_rung
      assign stage[j+1][k] = stage[j][k] | (stage[j][k-1] & bitsIn[j]);
    end
  end

  assign atLeast = stage[N];

  always_comb begin
    for (int k = 1; k <= N; k++) begin
      // R7
      thr_order_chk: assert (!atLeast[k] || atLeast[k-1])
        else $error("threshold ladder not monotonic at rung %0d", k);
    end
  end

endmodule

// File: rtl/bwc_rails.sv
// Pairs rung i of half A with rung M-i of half B and ORs the products
// onto rail e0 (even i) or rail e1 (odd i).
module bwc_rails
  import bwc_pkg::*;
#(
  parameter int M = 3
) (
  input  logic [M:0] vGe,
  input  logic [M:0] wGe,
  output railPair_t  pairOut
);

  logic [M:0] evenTerm;
  logic [M:0] oddTerm;

  for (genvar i = 0; i <= M; i++) begin : g_pair
    if ((i % 2) == 0) begin : g_even
      assign evenTerm[i] = vGe[i] & wGe[M-i];
      assign oddTerm[i]  = 1'b0;
    end else begin : g_odd
      assign evenTerm[i] = 1'b0;
      assign oddTerm[i]  = vGe[i] & wGe[M-i];
    end
  end

  assign pairOut.e0 = |evenTerm;
  assign pairOut.e1 = |oddTerm;

endmodule

// File: rtl/balanced_word_checker.sv
module balanced_word_checker
  import bwc_pkg::*;
#(
  parameter int M       = 3,
  parameter bit REG_IN  = 1'b1,
  parameter bit REG_OUT = 1'b1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [2*M-1:0] wordIn,
  output logic           railE0,
  output logic           railE1
);

  localparam int WORD_W = 2 * M;

  if (M < 2 || M > 8) begin : g_bad_m
    $error("M must lie in 2..8");
  end

  logic [WORD_W-1:0] wordStage;
  logic [M:0]        vGe;
  logic [M:0]        wGe;
  railPair_t         combPair;
  railPair_t         outPair;

  // Optional input register
  if (REG_IN) begin : g_in_reg
    always_ff @(posedge clk) begin
      if (!rstN) wordStage <= '0;
      else       wordStage <= wordIn;
    end
  end else begin : g_in_wire
    assign wordStage = wordIn;
  end

  bwc_threshold #(.N(M)) halfA_i (
    .bitsIn  (wordStage[M-1:0]),
    .atLeast (vGe)
  );

  bwc_threshold #(.N(M)) halfB_i (
    .bitsIn  (wordStage[WORD_W-1:M]),
    .atLeast (wGe)
  );

  bwc_rails #(.M(M)) rails_i (
    .vGe     (vGe),
    .wGe     (wGe),
    .pairOut (combPair)
  );

  // Optional output register
  if (REG_OUT) begin : g_out_reg
    always_ff @(posedge clk) begin
      if (!rstN) outPair <= RAIL_CLEAR;
      else       outPair <= combPair;
    end
  end else begin : g_out_wire
    assign outPair = combPair;
  end

  assign railE0 = outPair.e0;
  assign railE1 = outPair.e1;

  // ---------------- assertions ----------------
  logic primed;
  always_ff @(posedge clk) begin
    if (!rstN) primed <= 1'b0;
    else       primed <= 1'b1;
  end

  // R1 R2
  valid_one_rail_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(wordStage) == M) |-> (combPair.e0 != combPair.e1));

  // R1
  even_rail_chk: assert property (@(posedge clk) disable iff (!rstN)
    (($countones(wordStage) == M) && ($countones(wordStage[M-1:0]) % 2 == 0))
      |-> combPair.e0);

  // R3
  weight_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(wordStage) < M) |-> (!combPair.e0 && !combPair.e1));

  // R4
  weight_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(wordStage) > M) |-> (combPair.e0 && combPair.e1));

  if (REG_OUT) begin : g_out_chk
    // R5
    out_stage_chk: assert property (@(posedge clk) disable iff (!rstN)
      primed |-> (outPair == $past(combPair)));
    // R6
    rst_clear_chk: assert property (@(posedge clk)
      !rstN |=> (!railE0 && !railE1));
  end

  if (REG_IN) begin : g_in_chk
    // R5
    in_stage_chk: assert property (@(posedge clk) disable iff (!rstN)
      primed |-> (wordStage == $past(wordIn)));
  end

endmodule

// File: tb/balanced_word_checker_tb_top.sv
`timescale 1ns/1ps
module balanced_word_checker_tb_top;
  import bwc_pkg::*;

  localparam int M       = 4;
  localparam bit REG_IN  = 1'b1;
  localparam bit REG_OUT = 1'b1;
  localparam int LAT     = int'(REG_IN) + int'(REG_OUT);
  localparam int WORD_W  = 2 * M;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [WORD_W-1:0] wordIn = '0;
  logic              railE0;
  logic              railE1;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  balanced_word_checker #(.M(M), .REG_IN(REG_IN), .REG_OUT(REG_OUT)) dut_i (
    .clk    (clk),
    .rstN   (rstN),
    .wordIn (wordIn),
    .railE0 (railE0),
    .railE1 (railE1)
  );

  // Behavioural reference: population counts only.
  railPair_t expQ[$];
  string     tagQ[$];

  function automatic railPair_t modelPair(input logic [WORD_W-1:0] w);
    int total = 0;
    int lowCnt = 0;
    railPair_t r;
    for (int b = 0; b < WORD_W; b++) begin
      if (w[b]) begin
        total++;
        if (b < M) lowCnt++;
      end
    end
    if (total < M)       r = '{e0: 1'b0, e1: 1'b0};
    else if (total > M)  r = '{e0: 1'b1, e1: 1'b1};
    else if (lowCnt % 2 == 0) r = '{e0: 1'b1, e1: 1'b0};
    else                 r = '{e0: 1'b0, e1: 1'b1};
    return r;
  endfunction

  function automatic string tagFor(input logic [WORD_W-1:0] w);
    int total = $countones(w);
    if (total < M) return "R3";
    if (total > M) return "R4";
    if ($countones(w[M-1:0]) % 2 == 0) return "R1";
    return "R2";
  endfunction

  task automatic check(input string tag, input railPair_t exp);
    testsRun++;
    if (railE0 !== exp.e0 || railE1 !== exp.e1) begin
      testsFailed++;
      $display("FAIL %s: rails e0e1=%b%b expected %b%b", tag, railE0, railE1,
               exp.e0, exp.e1);
    end
  endtask

  // Drive one word at a falling edge and compare the word LAT cycles old.
  task automatic step(input logic [WORD_W-1:0] w);
    @(negedge clk);
    wordIn = w;
    expQ.push_back(modelPair(w));
    tagQ.push_back({tagFor(w), " (R5 latency)"});
    #1;
    if (expQ.size() > LAT) check(tagQ.pop_front(), expQ.pop_front());
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin : stimulus
    wordIn = {WORD_W{1'b1}};
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R6: registers cleared during reset
    check("R6 reset", RAIL_CLEAR);
    @(negedge clk);
    check("R6 reset", RAIL_CLEAR);
    wordIn = '0;
    rstN = 1'b1;
    // Pipeline contents right after reset read as cleared rails (R6)
    for (int k = 0; k < LAT; k++) begin
      expQ.push_back(RAIL_CLEAR);
      tagQ.push_back("R6 post-reset");
    end
    // Ascending sweep of the full word space
    for (int x = 0; x < (1 << WORD_W); x++) step(WORD_W'(x));
    // Descending sweep
    for (int x = (1 << WORD_W) - 1; x >= 0; x--) step(WORD_W'(x));
    // Alternating good/bad pairs at the weight boundary (R1 R2 R3 R4)
    step({{M{1'b0}}, {M{1'b1}}});
    step({{M{1'b0}}, {(M-1){1'b1}}, 1'b0});
    step({{M{1'b1}}, {M{1'b0}}});
    step({{(M-1){1'b0}}, 1'b1, {M{1'b1}}});
    // Flush
    for (int k = 0; k < LAT; k++) step('0);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule